// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Block Transfers

This block is a serial slave on a two-wire control bus. It gives a host controller access to a small bank of eight-bit control registers. The block runs on a fast system clock and oversamples the bus clock and data lines. It decodes start and stop conditions, recognises its own device address and answers four transfer types: single-byte write, single-byte read, block write and block read. The data line is open-drain, so the block drives it only through a pull-low enable.

A command byte follows the address in every transfer. Its top bit picks byte mode or block mode, and its low seven bits give the register index. In block mode a count byte comes before the data. The register index then advances by one after each byte, so a host can program or dump the whole bank in one transfer and may end the transfer after any whole byte. The register contents drive the block's outputs directly: nine output-enable bits, an amplitude-select flag with a three-bit amplitude step, and two fixed identification fields.

Top module: `ctl_regbus_slave`

## Requirements
- R1: After reset the registers hold index 0 = 0x00, 1 = 0x17, 2 = 0xF8, 3 = 0x08, 4 = 0x06 and 5 = 0xD8. The enable outputs are mapped as follows: out_en_o[0..3] = register 1 bits 4, 2, 1, 0, and out_en_o[4..8] = register 2 bits 7 down to 3. amp_prog_o is register 5 bit 7 and amp_step_o is register 5 bits 6:4. rev_code_o is register 3 bits 7:4 and vendor_id_o is register 3 bits 3:0.
- R2: The slave acknowledges only the address bytes 0xD6 (write) and 0xD7 (read), which carry the 7-bit address 0x6B. Any other address gets no acknowledge, and the transfer that follows changes no register.
- R3: In the command byte, bit 7 = 1 selects byte mode and bit 7 = 0 selects block mode. Bits 6:0 give the starting register index.
- R4: A byte write (0xD6, command, data, stop) stores the data byte in the indexed register and acknowledges every byte. The mapped outputs follow the new value.
- R5: A byte read (0xD6, command, repeated start, 0xD7) returns the indexed register most significant bit first. The host ends it with a NACK.
- R6: In a block write, the first byte after the command is a count that is acknowledged but neither stored nor enforced. Each data byte goes to the next register in ascending order from the index. A stop after any whole byte keeps the bytes already written.
- R7: In a block read, the first byte sent is the current value of register 4, followed by the registers in ascending order from the index. A host NACK ends the sending.
- R8: Register 3 is read-only. Writes to it are acknowledged but do not change it.
- R9: Indexes at or beyond 6 hold no register. Writes to them are acknowledged and dropped, and reads of them return 0x00.
- R10: A repeated start, even in the middle of a byte, clears the bit counter and begins a new address phase without ending the transfer.
- R11: A stop in the middle of a byte discards the partial byte.
- R12: The pull-low enable changes only while the synchronised SCL is low, and it is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | When high, the data line is pulled low |
| out_en_o | output | 9 | Output-enable bits taken from registers 1 and 2 |
| amp_prog_o | output | 1 | Programmed-amplitude select (register 5 bit 7) |
| amp_step_o | output | 3 | Amplitude step (register 5 bits 6:4) |
| rev_code_o | output | 4 | Revision field (register 3 bits 7:4) |
| vendor_id_o | output | 4 | Vendor field (register 3 bits 3:0) |

## Verification
The bench builds the block with its default parameters: six registers, address 0x6B and a two-stage synchroniser. With six registers, a sweep over command indexes 0 to 6 reaches every implemented register, the read-only slot and one index past the end in every transfer type. The bench holds each SCL quarter-period for six system clocks, which stays above the synchroniser and edge-detector latency. Block transfers therefore run the index across the end of the bank, and the early-stop and mid-byte cases land on known register values.

// File: rtl/ctl_regbus_pkg.sv
package ctl_regbus_pkg;

   localparam int unsigned OE_LO_REG = 1;
   localparam int unsigned OE_HI_REG = 2;
   localparam int unsigned ID_REG    = 3;
   localparam int unsigned COUNT_REG = 4;
   localparam int unsigned AMP_REG   = 5;
   localparam int unsigned MIN_REGS  = 6;
   localparam int unsigned OUT_CNT   = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_IGNORE
   } bus_state_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_CMD,
      PH_COUNT,
      PH_DATA
   } bus_phase_e;

   function automatic logic [7:0] reset_value(input int unsigned idx);
      case (idx)
         1:       return 8'h17;
         2:       return 8'hF8;
         3:       return 8'h08;
         4:       return 8'h06;
         5:       return 8'hD8;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ctl_regbus_sync.sv
module ctl_regbus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ctl_regbus_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_d     <= 1'b1;
         sda_d     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[STAGES-2:0], sda_i};
         scl_d     <= scl_chain[STAGES-1];
         sda_d     <= sda_chain[STAGES-1];
      end
   end

   assign scl_q     = scl_chain[STAGES-1];
   assign sda_q     = sda_chain[STAGES-1];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/ctl_regbus_bank.sv
module ctl_regbus_bank
   import ctl_regbus_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned RO_IDX   = ID_REG,
   localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int unsigned DEPTH   = 1 << IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [6:0]            wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [6:0]            rd_idx,
   output logic [7:0]            rd_data,
   output logic [DEPTH-1:0][7:0] regs_o
);

   if (NUM_REGS > 128) begin : g_bad_depth
      $error("ctl_regbus_bank: NUM_REGS exceeds the 7-bit index space");
   end

   logic wr_hit;
   logic rd_hit;

   assign wr_hit = wr_en && (32'(wr_idx) < NUM_REGS);
   assign rd_hit = (32'(rd_idx) < NUM_REGS);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i >= NUM_REGS) begin : g_absent
         assign regs_o[i] = 8'h00;
      end else if (i == RO_IDX) begin : g_fixed
         assign regs_o[i] = reset_value(i);
      end else begin : g_rw
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= reset_value(i);
            end else if (wr_hit && (wr_idx[IDX_W-1:0] == IDX_W'(i))) begin
               q <= wr_data;
            end
         end
         assign regs_o[i] = q;
      end
   end

   assign rd_data = rd_hit ? regs_o[rd_idx[IDX_W-1:0]] : 8'h00;

endmodule

// File: rtl/ctl_regbus_engine.sv
module ctl_regbus_engine
   import ctl_regbus_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h6B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_q,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] rd_data,
   output logic       sda_pull,
   output logic       wr_en,
   output logic [6:0] wr_idx,
   output logic [7:0] wr_data,
   output logic [6:0] rd_idx
);

   bus_state_e state;
   bus_phase_e phase;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic [7:0] txbyte;
   logic [6:0] ptr;
   logic [6:0] ptr_inc;
   logic       blk;
   logic       tx_next;
   logic       byte_end;

   assign byte_end = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
   assign ptr_inc  = (ptr == 7'h7F) ? ptr : ptr + 7'd1;
   assign wr_en    = byte_end && (phase == PH_DATA) && !start_det && !stop_det;
   assign wr_idx   = ptr;
   assign wr_data  = shreg;
   assign rd_idx   = ((state == ST_RX) && (phase == PH_ADDR) && blk) ? 7'(COUNT_REG) : ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= PH_ADDR;
         bitcnt   <= 4'd0;
         shreg    <= 8'h00;
         txbyte   <= 8'h00;
         ptr      <= 7'd0;
         blk      <= 1'b0;
         tx_next  <= 1'b0;
         sda_pull <= 1'b0;
      end else if (start_det) begin
         state    <= ST_RX;
         phase    <= PH_ADDR;
         bitcnt   <= 4'd0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         bitcnt   <= 4'd0;
         sda_pull <= 1'b0;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise && (bitcnt != 4'd8)) begin
                  shreg  <= {shreg[6:0], sda_q};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_end) begin
                  bitcnt   <= 4'd0;
                  state    <= ST_ACK;
                  sda_pull <= 1'b1;
                  tx_next  <= 1'b0;
                  case (phase)
                     PH_ADDR: begin
                        if (shreg[7:1] != DEV_ADDR) begin
                           state    <= ST_IGNORE;
                           sda_pull <= 1'b0;
                        end else if (shreg[0]) begin
                           tx_next <= 1'b1;
                           txbyte  <= rd_data;
                           if (!blk) ptr <= ptr_inc;
                        end else begin
                           phase <= PH_CMD;
                        end
                     end
                     PH_CMD: begin
                        ptr   <= shreg[6:0];
                        blk   <= ~shreg[7];
                        phase <= shreg[7] ? PH_DATA : PH_COUNT;
                     end
                     PH_COUNT: phase <= PH_DATA;
                     default:  ptr   <= ptr_inc;
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  if (tx_next) begin
                     state    <= ST_TX;
                     sda_pull <= ~txbyte[7];
                  end else begin
                     state    <= ST_RX;
                     sda_pull <= 1'b0;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     state    <= ST_MACK;
                     sda_pull <= 1'b0;
                     bitcnt   <= 4'd0;
                  end else begin
                     txbyte   <= {txbyte[6:0], 1'b0};
                     sda_pull <= ~txbyte[6];
                     bitcnt   <= bitcnt + 4'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  if (sda_q) begin
                     state <= ST_IGNORE;
                  end else begin
                     txbyte  <= rd_data;
                     ptr     <= ptr_inc;
                     tx_next <= 1'b1;
                     state   <= ST_ACK;
                  end
               end
            end
            default: sda_pull <= 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/ctl_regbus_slave.sv
module ctl_regbus_slave
   import ctl_regbus_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h6B,
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int unsigned DEPTH      = 1 << IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pull_o,
   output logic [OUT_CNT-1:0] out_en_o,
   output logic               amp_prog_o,
   output logic [2:0]         amp_step_o,
   output logic [3:0]         rev_code_o,
   output logic [3:0]         vendor_id_o
);

   if (NUM_REGS < MIN_REGS) begin : g_bad_regs
      $error("ctl_regbus_slave: NUM_REGS must cover the mapped registers");
   end

   logic                  scl_s;
   logic                  sda_s;
   logic                  scl_rise;
   logic                  scl_fall;
   logic                  start_det;
   logic                  stop_det;
   logic                  wr_en;
   logic [6:0]            wr_idx;
   logic [7:0]            wr_data;
   logic [6:0]            rd_idx;
   logic [7:0]            rd_data;
   logic [DEPTH-1:0][7:0] regs;

   ctl_regbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_q     (scl_s),
      .sda_q     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ctl_regbus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_q     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .sda_pull  (sda_pull_o),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx)
   );

   ctl_regbus_bank #(.NUM_REGS(NUM_REGS), .RO_IDX(ID_REG)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .regs_o  (regs)
   );

   for (genvar k = 0; k < OUT_CNT; k++) begin : g_oe
      if (k == 0) begin : g_first
         assign out_en_o[k] = regs[OE_LO_REG][4];
      end else if (k < 4) begin : g_low
         assign out_en_o[k] = regs[OE_LO_REG][3-k];
      end else begin : g_high
         assign out_en_o[k] = regs[OE_HI_REG][11-k];
      end
   end

   assign amp_prog_o  = regs[AMP_REG][7];
   assign amp_step_o  = regs[AMP_REG][6:4];
   assign rev_code_o  = regs[ID_REG][7:4];
   assign vendor_id_o = regs[ID_REG][3:0];

endmodule

// File: rtl/ctl_regbus_chk.sv
module ctl_regbus_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_q,
   input logic       scl_fall,
   input logic       stop_det,
   input logic       sda_pull_o,
   input logic [8:0] out_en_o,
   input logic       amp_prog_o,
   input logic [2:0] amp_step_o,
   input logic [3:0] rev_code_o,
   input logic [3:0] vendor_id_o
);

   // R1: values seen as reset is released
   a_r1_reset_outputs: assert property (@(posedge clk)
      $rose(rst_n) |-> (out_en_o == 9'h1FF && amp_prog_o && amp_step_o == 3'd5
                        && rev_code_o == 4'd0 && vendor_id_o == 4'd8));

   // R8: identification fields never move
   a_r8_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(rev_code_o) && $stable(vendor_id_o));

   // R4: register outputs update only right after an SCL falling edge
   a_r4_update_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({out_en_o, amp_prog_o, amp_step_o}) |-> $past(scl_fall));

   // R12: the pull enable moves only while SCL is low
   a_r12_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_q);

   // R12: the line is released after a stop
   a_r12_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull_o);

endmodule

bind ctl_regbus_slave ctl_regbus_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_q       (scl_s),
   .scl_fall    (scl_fall),
   .stop_det    (stop_det),
   .sda_pull_o  (sda_pull_o),
   .out_en_o    (out_en_o),
   .amp_prog_o  (amp_prog_o),
   .amp_step_o  (amp_step_o),
   .rev_code_o  (rev_code_o),
   .vendor_id_o (vendor_id_o)
);

// File: tb/ctl_regbus_slave_tb_top.sv
module ctl_regbus_slave_tb_top;

   localparam int NREG = 6;
   localparam int Q    = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_pull_o;
   logic [8:0] out_en_o;
   logic       amp_prog_o;
   logic [2:0] amp_step_o;
   logic [3:0] rev_code_o;
   logic [3:0] vendor_id_o;

   int   total = 0;
   int   bad = 0;
   bit   done = 0;
   logic [7:0] ref_m [NREG];
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];
   logic [7:0] rcount;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull_o;

   ctl_regbus_slave dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_pull_o  (sda_pull_o),
      .out_en_o    (out_en_o),
      .amp_prog_o  (amp_prog_o),
      .amp_step_o  (amp_step_o),
      .rev_code_o  (rev_code_o),
      .vendor_id_o (vendor_id_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   function automatic logic [7:0] rd_ref(input int idx);
      return (idx < NREG) ? ref_m[idx] : 8'h00;
   endfunction

   function automatic void wr_ref(input int idx, input logic [7:0] d);
      if (idx < NREG && idx != 3) ref_m[idx] = d;
   endfunction

   function automatic logic [8:0] exp_oe();
      logic [8:0] e;
      e[0] = ref_m[1][4]; e[1] = ref_m[1][2]; e[2] = ref_m[1][1]; e[3] = ref_m[1][0];
      for (int k = 4; k < 9; k++) e[k] = ref_m[2][11-k];
      return e;
   endfunction

   task automatic check_ports(input string req);
      check({req, " out_en"}, int'(out_en_o), int'(exp_oe()));
      check({req, " amp_prog"}, int'(amp_prog_o), int'(ref_m[5][7]));
      check({req, " amp_step"}, int'(amp_step_o), int'(ref_m[5][6:4]));
      check({req, " rev"}, int'(rev_code_o), int'(ref_m[3][7:4]));
      check({req, " vendor"}, int'(vendor_id_o), int'(ref_m[3][3:0]));
   endtask

   task automatic bus_start();
      wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
      check("R12 released after stop", int'(sda_pull_o), 0);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         wq(1); sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); ack = !sda_line; wq(1); scl_m = 1'b0;
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(2); scl_m = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_m = 1'b0;
      end
      wq(1); sda_m = nack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1); sda_m = 1'b1;
   endtask

   task automatic byte_write(input logic [7:0] addr, input int idx, input logic [7:0] d, output bit acks);
      bit a0, a1, a2;
      bus_start();
      send_byte(addr, a0); send_byte(8'h80 | 8'(idx), a1); send_byte(d, a2);
      bus_stop();
      acks = a0 & a1 & a2;
   endtask

   task automatic byte_read(input int idx, output logic [7:0] d);
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hD6, a0); send_byte(8'h80 | 8'(idx), a1);
      bus_start();
      send_byte(8'hD7, a2);
      recv_byte(1'b1, d);
      bus_stop();
      check("R5 read acks", int'(a0 & a1 & a2), 1);
   endtask

   task automatic block_write(input int idx, input logic [7:0] cnt, input int n, output bit acks);
      bit a;
      acks = 1;
      bus_start();
      send_byte(8'hD6, a); acks &= a;
      send_byte(8'(idx), a); acks &= a;
      send_byte(cnt, a); acks &= a;
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], a); acks &= a;
      end
      bus_stop();
   endtask

   task automatic block_read(input int idx, input int n);
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hD6, a0); send_byte(8'(idx), a1);
      bus_start();
      send_byte(8'hD7, a2);
      recv_byte(n == 0, rcount);
      for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
      bus_stop();
      check("R7 block read acks", int'(a0 & a1 & a2), 1);
   endtask

   initial begin
      bit ok;
      logic [7:0] d;
      for (int i = 0; i < NREG; i++) ref_m[i] = (i == 1) ? 8'h17 : (i == 2) ? 8'hF8 :
         (i == 3) ? 8'h08 : (i == 4) ? 8'h06 : (i == 5) ? 8'hD8 : 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: reset values at the ports and through reads
      check_ports("R1 reset");
      check("R1 pull idle", int'(sda_pull_o), 0);
      for (int i = 0; i < NREG; i++) begin
         byte_read(i, d);
         check("R1 reset readback", int'(d), int'(rd_ref(i)));
      end

      // R4 / R3 / R8 / R9: byte writes over every index plus one beyond
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i <= NREG; i++) begin
            logic [7:0] v;
            v = (p == 0) ? 8'hA5 ^ 8'(i * 17) : 8'h3C + 8'(i * 29);
            byte_write(8'hD6, i, v, ok);
            check("R4 byte write acks", int'(ok), 1);
            wr_ref(i, v);
            byte_read(i, d);
            if (i == 3) check("R8 read-only register", int'(d), int'(rd_ref(i)));
            else if (i >= NREG) check("R9 beyond bank reads zero", int'(d), 0);
            else check("R4 R3 byte write readback", int'(d), int'(rd_ref(i)));
            check_ports("R4 ports");
         end
      end

      // R6 / R7 / R9: block writes from every start, running past the end
      for (int s = 0; s <= NREG; s++) begin
         int n;
         n = NREG + 1 - s;
         for (int k = 0; k < n; k++) wbuf[k] = 8'(s * 16 + k * 3 + 1);
         block_write(s, 8'(n), n, ok);
         check("R6 block write acks", int'(ok), 1);
         for (int k = 0; k < n; k++) wr_ref(s + k, wbuf[k]);
         block_read(0, NREG);
         check("R7 count from register 4", int'(rcount), int'(ref_m[4]));
         for (int k = 0; k < NREG; k++) check("R6 block write contents", int'(rbuf[k]), int'(rd_ref(k)));
         check_ports("R6 ports");
      end

      // R7 / R9: block reads from every start
      for (int s = 0; s <= NREG; s++) begin
         block_read(s, NREG + 1 - s);
         check("R7 block read count", int'(rcount), int'(ref_m[4]));
         for (int k = 0; k < NREG + 1 - s; k++)
            check("R7 R9 block read data", int'(rbuf[k]), int'(rd_ref(s + k)));
      end

      // R7: count-only block read
      block_read(2, 0);
      check("R7 count-only read", int'(rcount), int'(ref_m[4]));

      // R6: early stop after two data bytes of a longer block
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      block_write(0, 8'd6, 2, ok);
      check("R6 early stop acks", int'(ok), 1);
      wr_ref(0, 8'h11); wr_ref(1, 8'h22);
      for (int i = 0; i < NREG; i++) begin
         byte_read(i, d);
         check("R6 early stop contents", int'(d), int'(rd_ref(i)));
      end

      // R11: stop in the middle of a data byte
      bus_start();
      send_byte(8'hD6, ok); send_byte(8'h85, ok);
      send_bits(8'h00, 4);
      bus_stop();
      byte_read(5, d);
      check("R11 partial byte discarded", int'(d), int'(rd_ref(5)));
      check_ports("R11 ports");

      // R2: wrong address gets no acknowledge and changes nothing
      bus_start();
      send_byte(8'hD4, ok);
      check("R2 foreign address not acked", int'(ok), 0);
      send_byte(8'h80, ok); send_byte(8'h99, ok);
      bus_stop();
      byte_read(0, d);
      check("R2 foreign write ignored", int'(d), int'(rd_ref(0)));

      // R10: repeated start in the middle of a byte restarts the address phase
      bus_start();
      send_byte(8'hD6, ok); send_byte(8'h80, ok);
      send_bits(8'hFF, 3);
      bus_start();
      send_byte(8'hD6, ok);
      check("R10 address acked after repeated start", int'(ok), 1);
      send_byte(8'h82, ok); send_byte(8'h55, ok);
      bus_stop();
      wr_ref(2, 8'h55);
      byte_read(2, d);
      check("R10 write after repeated start", int'(d), 8'h55);
      byte_read(0, d);
      check("R10 first command left no write", int'(d), int'(rd_ref(0)));
      check_ports("R10 ports");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule